// File: doc/BRIEF.md
# Card Configuration Register File

This block serves the attribute-memory side of a removable storage card's host interface. The host reaches it through a byte-wide attribute port. Reads are combinational and writes take effect on the clock edge. Addresses below a fixed configuration base return bytes of a read-only card information table, which here is a small computed test table. From the base upward, a handful of configuration registers live at even offsets.

Three registers hold state. The option register carries the addressing-mode field, which the neighbouring address decoder consumes, and a soft-reset bit. The configuration status register holds sticky host-set bits, a power-down bit and an interrupt-status bit that tracks the disk engine. The pin replacement register holds a card-ready bit and a host-ready bit. The block combines the interrupt-status bit with the option soft-reset bit and with the interrupt-mask and reset bits of the device control register to form the card interrupt request. It also emits a one-cycle pulse whenever software asks for a soft reset.

Top module: `card_cfg_regs`

## Requirements
- R1: An attribute read below CIS_LEN returns table byte ((a*29+7) mod 256) XOR 0x5A, where a is the address.
- R2: Reads at or above CIS_LEN and below BASE return 0. Reads of the socket offset (BASE+6) and of any other undefined offset at or above BASE return 0. Writes to any of these addresses leave every register and output unchanged.
- R3: A write to BASE+0 stores the data ANDed with 0xCF. The next read of BASE+0 returns that value, and mode_o shows its bits 1:0 from the following cycle.
- R4: After hardware reset, the option reads 0x00 and mode_o is 0 (memory-mapped). The status register is 0 apart from bit 1, which is 1 while eng_irq is low. The pin register reads 0x0C, host_ready_o is 0 and irq_o is 0.
- R5: A write to BASE+0 with bit 7 set raises srst_pulse_o for exactly the following cycle. It also clears status bits 6,5,4,2 and both pin bits, while option bit 7 stays held.
- R6: A read of BASE+2 returns the status byte with bit 1 forced to 0 while ctl_irq_mask is high.
- R7: A read of BASE+4 returns 0x0C ORed with the card-ready bit in bit 1.
- R8: A write to BASE+2 sets card-ready when written bit 2 differs from stored power-down bit 2. It then ORs data AND 0x74 into the status. These bits are sticky until a reset.
- R9: A write to BASE+4 loads host-ready (host_ready_o) from data bit 0 and leaves card-ready unchanged.
- R10: irq_o is high exactly when status bit 1 is 0, ctl_irq_mask is 0, ctl_soft_reset is 0 and option bit 7 is 0. It follows the control inputs without a clock.
- R11: Status bit 1 takes the inverse of eng_irq as sampled on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| attr_addr | input | ADDR_W | Attribute address |
| attr_we | input | 1 | Write strobe for one cycle |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Combinational read data |
| eng_irq | input | 1 | Interrupt request level from the disk engine |
| ctl_irq_mask | input | 1 | Interrupt-disable bit of device control |
| ctl_soft_reset | input | 1 | Soft-reset bit of device control |
| mode_o | output | 2 | Addressing-mode field of the option register |
| host_ready_o | output | 1 | Host-ready pin bit |
| srst_pulse_o | output | 1 | One-cycle soft-reset request pulse |
| irq_o | output | 1 | Card interrupt request |

## Verification
The hardest states to reach from the ports are the card-ready side effect and its interaction with the sticky power-down bit. Once power-down is set, every later status write with bit 2 low counts as a toggle, and a soft reset must then clear both bits together. Random status, pin and option writes with random data are interleaved with random engine and control levels, so power-down toggles, re-sets and soft resets occur in many orders. Directed sequences pin down the first toggle, the held soft-reset bit suppressing irq_o, and reads at the table and base boundaries.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
  localparam int unsigned OFS_OPTION = 0;
  localparam int unsigned OFS_STATUS = 2;
  localparam int unsigned OFS_PINS   = 4;
  localparam int unsigned OFS_SOCKET = 6;

  localparam logic [7:0] OPT_KEEP_MASK  = 8'hCF;
  localparam logic [7:0] STAT_SET_MASK  = 8'h74;
  localparam logic [7:0] PINS_FIXED     = 8'h0C;

  localparam int unsigned OPT_SRST_BIT  = 7;
  localparam int unsigned STAT_PD_BIT   = 2;
  localparam int unsigned STAT_INT_BIT  = 1;
  localparam int unsigned PIN_CRDY_BIT  = 1;
  localparam int unsigned PIN_HRDY_BIT  = 0;

  typedef enum logic [1:0] {
    MODE_MEMORY = 2'd0,
    MODE_IO_ANY = 2'd1,
    MODE_IO_PRI = 2'd2,
    MODE_IO_SEC = 2'd3
  } addr_mode_e;

  function automatic logic [7:0] cis_byte(input logic [7:0] idx);
    logic [7:0] mix;
    mix = idx * 8'd29 + 8'd7;
    return mix ^ 8'h5A;
  endfunction

  function automatic logic [7:0] status_view(input logic [7:0] stat, input logic hide_int);
    logic [7:0] v;
    v = stat;
    if (hide_int) v[STAT_INT_BIT] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/card_cis_rom.sv
module card_cis_rom #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned CIS_LEN = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  import card_cfg_pkg::*;
  localparam logic [ADDR_W-1:0] LEN = ADDR_W'(CIS_LEN);

  always_comb begin
    if (addr < LEN) data = cis_byte(addr[7:0]);
    else            data = 8'h00;
  end
endmodule

// File: rtl/card_cfg_decode.sv
module card_cfg_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BASE   = 'h200
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              in_table,
  output logic [2:0]        sel,
  output logic [2:0]        wr
);
  import card_cfg_pkg::*;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam int unsigned OFFS [3] = '{OFS_OPTION, OFS_STATUS, OFS_PINS};

  assign in_table = (addr < BASE_A);

  for (genvar g = 0; g < 3; g++) begin : g_sel
    assign sel[g] = (addr == BASE_A + ADDR_W'(OFFS[g]));
    assign wr[g]  = we && sel[g];
  end
endmodule

// File: rtl/card_cfg_state.sv
module card_cfg_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wdata,
  input  logic       wr_opt,
  input  logic       wr_stat,
  input  logic       wr_pins,
  input  logic       eng_irq,
  output logic [7:0] opt_q,
  output logic [7:0] stat_q,
  output logic       crdy_q,
  output logic       hrdy_q,
  output logic       srst_pulse_q,
  output logic       soft_req
);
  import card_cfg_pkg::*;

  logic       pd_toggle;
  logic [7:0] stat_next;

  assign soft_req  = wr_opt && wdata[OPT_SRST_BIT];
  assign pd_toggle = wr_stat && (stat_q[STAT_PD_BIT] != wdata[STAT_PD_BIT]);

  always_comb begin
    stat_next = stat_q;
    if (soft_req)     stat_next = 8'h00;
    else if (wr_stat) stat_next = stat_q | (wdata & STAT_SET_MASK);
    stat_next[STAT_INT_BIT] = ~eng_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q        <= 8'h00;
      stat_q       <= 8'h02;
      crdy_q       <= 1'b0;
      hrdy_q       <= 1'b0;
      srst_pulse_q <= 1'b0;
    end else begin
      stat_q       <= stat_next;
      srst_pulse_q <= soft_req;
      if (wr_opt) opt_q <= wdata & OPT_KEEP_MASK;
      if (soft_req) begin
        crdy_q <= 1'b0;
        hrdy_q <= 1'b0;
      end else begin
        if (pd_toggle) crdy_q <= 1'b1;
        if (wr_pins)   hrdy_q <= wdata[PIN_HRDY_BIT];
      end
    end
  end
endmodule

// File: rtl/card_irq_gen.sv
module card_irq_gen (
  input  logic stat_int,
  input  logic ctl_irq_mask,
  input  logic ctl_soft_reset,
  input  logic opt_srst,
  output logic irq
);
  logic blocked;
  assign blocked = ctl_irq_mask | ctl_soft_reset | opt_srst;
  assign irq     = ~stat_int & ~blocked;
endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned BASE    = 'h200,
  parameter int unsigned CIS_LEN = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] attr_addr,
  input  logic              attr_we,
  input  logic [7:0]        attr_wdata,
  output logic [7:0]        attr_rdata,
  input  logic              eng_irq,
  input  logic              ctl_irq_mask,
  input  logic              ctl_soft_reset,
  output logic [1:0]        mode_o,
  output logic              host_ready_o,
  output logic              srst_pulse_o,
  output logic              irq_o
);
  import card_cfg_pkg::*;

  logic       in_table;
  logic [2:0] sel, wr;
  logic       wr_opt, wr_stat, wr_pins, soft_req;
  logic [7:0] opt_q, stat_q, cis_data;
  logic       crdy_q, hrdy_q;

  card_cis_rom #(.ADDR_W(ADDR_W), .CIS_LEN(CIS_LEN)) u_rom (
    .addr(attr_addr), .data(cis_data));

  card_cfg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(attr_addr), .we(attr_we), .in_table(in_table), .sel(sel), .wr(wr));

  assign wr_opt  = wr[0];
  assign wr_stat = wr[1];
  assign wr_pins = wr[2];

  card_cfg_state u_state (
    .clk(clk), .rst_n(rst_n), .wdata(attr_wdata),
    .wr_opt(wr_opt), .wr_stat(wr_stat), .wr_pins(wr_pins), .eng_irq(eng_irq),
    .opt_q(opt_q), .stat_q(stat_q), .crdy_q(crdy_q), .hrdy_q(hrdy_q),
    .srst_pulse_q(srst_pulse_o), .soft_req(soft_req));

  card_irq_gen u_irq (
    .stat_int(stat_q[STAT_INT_BIT]), .ctl_irq_mask(ctl_irq_mask),
    .ctl_soft_reset(ctl_soft_reset), .opt_srst(opt_q[OPT_SRST_BIT]), .irq(irq_o));

  assign mode_o       = opt_q[1:0];
  assign host_ready_o = hrdy_q;

  always_comb begin
    if (in_table)    attr_rdata = cis_data;
    else if (sel[0]) attr_rdata = opt_q;
    else if (sel[1]) attr_rdata = status_view(stat_q, ctl_irq_mask);
    else if (sel[2]) attr_rdata = PINS_FIXED | (8'(crdy_q) << PIN_CRDY_BIT);
    else             attr_rdata = 8'h00;
  end
endmodule

// File: rtl/card_cfg_chk.sv
module card_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] attr_wdata,
  input logic       eng_irq,
  input logic       ctl_irq_mask,
  input logic       ctl_soft_reset,
  input logic       wr_opt,
  input logic       wr_pins,
  input logic       soft_req,
  input logic [7:0] opt_q,
  input logic [7:0] stat_q,
  input logic       crdy_q,
  input logic [1:0] mode_o,
  input logic       host_ready_o,
  input logic       srst_pulse_o,
  input logic       irq_o
);
  assert_mode_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opt |=> mode_o == $past(attr_wdata[1:0]));

  assert_pulse_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req |=> srst_pulse_o);

  assert_pulse_only_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_req) |=> !srst_pulse_o);

  assert_crdy_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (crdy_q && !soft_req) |=> crdy_q);

  assert_hrdy_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pins && !soft_req) |=> host_ready_o == $past(attr_wdata[0]));

  assert_irq_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_irq_mask || ctl_soft_reset || opt_q[7] || stat_q[1]) |-> !irq_o);

  assert_int_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q[1] == !$past(eng_irq));
endmodule

bind card_cfg_regs card_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .attr_wdata(attr_wdata), .eng_irq(eng_irq),
  .ctl_irq_mask(ctl_irq_mask), .ctl_soft_reset(ctl_soft_reset),
  .wr_opt(wr_opt), .wr_pins(wr_pins), .soft_req(soft_req),
  .opt_q(opt_q), .stat_q(stat_q), .crdy_q(crdy_q), .mode_o(mode_o),
  .host_ready_o(host_ready_o), .srst_pulse_o(srst_pulse_o), .irq_o(irq_o));

// File: tb/sim_card_cfg_regs.sv
module sim_card_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int BASE = 'h200;
  localparam int CIS_LEN = 24;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] attr_addr = '0;
  logic attr_we = 0;
  logic [7:0] attr_wdata = 0, attr_rdata;
  logic eng_irq = 0, ctl_irq_mask = 0, ctl_soft_reset = 0;
  logic [1:0] mode_o;
  logic host_ready_o, srst_pulse_o, irq_o;

  int checks = 0, errors = 0;

  // bench model
  logic [7:0] m_opt = 0, m_stick = 0;
  logic m_int = 1, m_crdy = 0, m_hrdy = 0, m_pulse = 0;

  card_cfg_regs #(.ADDR_W(ADDR_W), .BASE(BASE), .CIS_LEN(CIS_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_we(attr_we),
    .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .eng_irq(eng_irq),
    .ctl_irq_mask(ctl_irq_mask), .ctl_soft_reset(ctl_soft_reset),
    .mode_o(mode_o), .host_ready_o(host_ready_o), .srst_pulse_o(srst_pulse_o),
    .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] tbl(input int a);
    return 8'(((a * 29 + 7) % 256) ^ 90);
  endfunction

  function automatic logic [7:0] want_read(input int a);
    logic [7:0] s;
    if (a < CIS_LEN) return tbl(a);
    if (a < BASE) return 8'h00;
    s = m_stick | (m_int ? 8'h02 : 8'h00);
    case (a - BASE)
      0: return m_opt;
      2: return ctl_irq_mask ? (s & 8'hFD) : s;
      4: return 8'h0C | (m_crdy ? 8'h02 : 8'h00);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int a;
    a = int'(attr_addr);
    if (a < CIS_LEN) check({"R1 ", tag}, attr_rdata, want_read(a));
    else if (a < BASE || a - BASE > 4 || (a - BASE) % 2 == 1 || a - BASE == 6)
      check({"R2 ", tag}, attr_rdata, want_read(a));
    else if (a == BASE)     check({"R3 ", tag}, attr_rdata, want_read(a));
    else if (a == BASE + 2) check({"R6 R8 R11 ", tag}, attr_rdata, want_read(a));
    else                    check({"R7 ", tag}, attr_rdata, want_read(a));
    check({"R3 mode ", tag}, mode_o, m_opt[1:0]);
    check({"R9 ", tag}, host_ready_o, m_hrdy);
    check({"R5 ", tag}, srst_pulse_o, m_pulse);
    check({"R10 ", tag}, irq_o, !m_int && !ctl_irq_mask && !ctl_soft_reset && !m_opt[7]);
  endtask

  // one clock: drive at negedge, model at posedge, check after
  task automatic step(input logic we, input int a, input logic [7:0] d,
                      input logic eng, input logic msk, input logic crst, input string tag);
    int off;
    @(negedge clk);
    attr_we = we; attr_addr = ADDR_W'(a); attr_wdata = d;
    eng_irq = eng; ctl_irq_mask = msk; ctl_soft_reset = crst;
    @(posedge clk);
    off = a - BASE;
    m_pulse = 0;
    if (we && a >= BASE) begin
      if (off == 0) begin
        m_opt = d & 8'hCF;
        if (d[7]) begin m_stick = 0; m_crdy = 0; m_hrdy = 0; m_pulse = 1; end
      end else if (off == 2) begin
        if (m_stick[2] != d[2]) m_crdy = 1;
        m_stick = m_stick | (d & 8'h74);
      end else if (off == 4) begin
        m_hrdy = d[0];
      end
    end
    m_int = !eng;
    #1;
    attr_we = 0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R4: reset state during and after reset
    check("R4 irq in reset", irq_o, 0);
    check("R4 mode in reset", mode_o, 0);
    @(negedge clk); rst_n = 1;
    attr_addr = ADDR_W'(BASE); #1 check("R4 option", attr_rdata, 8'h00);
    attr_addr = ADDR_W'(BASE + 2); #1 check("R4 status", attr_rdata, 8'h02);
    attr_addr = ADDR_W'(BASE + 4); #1 check("R4 pins", attr_rdata, 8'h0C);
    check("R4 hrdy", host_ready_o, 0);
    check("R4 irq", irq_o, 0);

    // R1/R2 boundaries
    step(0, 0, 0, 0, 0, 0, "table first");
    step(0, CIS_LEN - 1, 0, 0, 0, 0, "table last");
    step(0, CIS_LEN, 0, 0, 0, 0, "past table");
    step(0, BASE - 1, 0, 0, 0, 0, "below base");
    step(1, 5, 8'hFF, 0, 0, 0, "table write ignored");
    step(1, BASE + 6, 8'hFF, 0, 0, 0, "socket ignored");
    step(1, BASE + 8, 8'hFF, 0, 0, 0, "undefined ignored");
    step(0, BASE + 4, 0, 0, 0, 0, "pins after ignored writes");
    // R3 mask
    step(1, BASE, 8'h7F, 0, 0, 0, "opt mask");
    step(0, BASE, 0, 0, 0, 0, "opt read");
    // R8 power-down toggle
    step(1, BASE + 2, 8'h04, 0, 0, 0, "pd set");
    step(0, BASE + 4, 0, 0, 0, 0, "crdy after pd");
    step(1, BASE + 2, 8'hFB, 0, 0, 0, "pd back toggle");
    step(0, BASE + 2, 0, 0, 0, 0, "stat sticky");
    // R9
    step(1, BASE + 4, 8'hFF, 0, 0, 0, "hrdy set");
    step(1, BASE + 4, 8'hFE, 0, 0, 0, "hrdy clear keeps crdy");
    // R11 / R10 / R6
    step(0, BASE + 2, 0, 1, 0, 0, "engine irq");
    step(0, BASE + 2, 0, 1, 1, 0, "masked hides int");
    step(0, BASE + 2, 0, 1, 0, 1, "ctl reset blocks");
    // R5 soft reset held
    step(1, BASE, 8'h80, 1, 0, 0, "soft reset");
    step(0, BASE + 4, 0, 1, 0, 0, "after soft reset");
    step(1, BASE, 8'h03, 1, 0, 0, "release soft reset");

    for (int i = 0; i < 3000; i++) begin
      int pick, a;
      logic [7:0] d;
      pick = int'($urandom % 10);
      d = 8'($urandom);
      case (pick)
        0: a = int'($urandom % 64);
        1: a = BASE + int'($urandom % 10);
        2: a = BASE;
        3, 4: a = BASE + 2;
        5, 6: a = BASE + 4;
        default: a = int'($urandom % (1 << ADDR_W));
      endcase
      if (a == BASE && ($urandom % 4) != 0) d[7] = 0;
      step(($urandom % 2) == 1, a, d, ($urandom % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 6) == 0, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule